// File: doc/BRIEF.md
# Single-Level Page-Table Walk MMU

This block sits between a processor's memory port and a cache or memory port. It turns processor addresses into physical addresses by reading one entry from a flat page table in memory. A request made in user mode goes through a fixed sequence of states. The block first checks the page index against the table length. It then reads the table entry and checks the entry's valid bit and its access rights. After that it builds the physical address and performs the load or store. A request made in system mode skips all of this and uses the processor address as is.

Both ports use a request/busy handshake. The processor raises `cpu_req` for one accepted cycle. The block captures the address, direction and store data, then holds `cpu_busy` high until the data access ends or a fault is reported. On the memory side the block raises a read or write strobe and waits while `mem_busy` is high. A fault ends the request with a one-cycle flag and a cause code. The stall input lets surrounding logic stop a new walk from starting while the mode, table origin or table length is being changed, or while a return from an exception is pending.

Top module: `pt_walk_mmu`

## Requirements
- R1: In user mode the first memory access is a read of the table entry at `{pt_origin, 12'h000} + 4 * va[31:12]`.
- R2: An entry holds the physical page number in bits 31:12, the read right in bit 2, the write right in bit 1 and the valid flag in bit 0. The data access goes to `{entry[31:12], va[11:0]}`.
- R3: If `va[31:12] >= pt_length`, the request ends with cause 1 and no memory access. An index of `pt_length - 1` is translated normally.
- R4: An entry whose valid bit is 0 ends the request with cause 2 after exactly one memory access (the entry read).
- R5: A load needs entry bit 2 and a store needs entry bit 1. If the needed right is missing, the request ends with cause 2 and no data access.
- R6: With `mode_user = 0` at acceptance, a single memory access goes to the unchanged processor address, and no table read or check takes place.
- R7: `cpu_busy` rises the cycle after acceptance and stays high without a gap until the request ends. It then falls in the cycle after the final memory access completes, or together with a fault flag. With memory latency L, a user access keeps busy high for 4+2L cycles, a length fault for 1, an entry fault for 3+L and a system access for 2+L.
- R8: When busy falls after a load with no fault, `cpu_rdata` holds the word that memory returned for the data access.
- R9: A store drives the captured store data on `mem_wdata`, and that word is written at the data address.
- R10: `cpu_excp` is a one-cycle pulse in the cycle busy falls. `cpu_cause` is 1 for a length fault and 2 for an entry fault. `cpu_excp` stays 0 when a request ends normally.
- R11: While `mem_busy` is high, the active strobe and `mem_addr` stay unchanged. Read and write strobes are never both high.
- R12: While `walk_stall` is high, no request is accepted: busy stays low and no strobe is raised. A request still pending when the stall drops then proceeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, accepted when idle and not stalled |
| cpu_wr | input | 1 | 1 = store, 0 = load or fetch |
| cpu_addr | input | 32 | Processor (virtual) address |
| cpu_wdata | input | 32 | Store data |
| cpu_busy | output | 1 | Request in progress |
| cpu_rdata | output | 32 | Load data, valid when busy falls |
| cpu_excp | output | 1 | One-cycle fault flag |
| cpu_cause | output | 2 | Fault cause: 1 length, 2 entry |
| mode_user | input | 1 | 1 = translate, 0 = pass through |
| pt_origin | input | 20 | Page-table base, upper address bits |
| pt_length | input | 20 | Number of table entries |
| walk_stall | input | 1 | Blocks acceptance of a new request |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| mem_busy | input | 1 | Memory not yet done with the strobed access |

## Verification
The walk is driven through a table whose entries carry every mix of rights and validity that matters: full rights, read only, write only, invalid, and the last legal index next to the first illegal one. Each load and store against these entries shows whether the right bit is chosen by direction and whether faults stop before the data access. System-mode loads and stores, including a read-back of a written word, separate the pass-through path from the translated path. Memory latencies of 0, 2 and 3 cycles, together with a request held behind the stall input, show whether busy lengths and strobe holding follow the memory and not a fixed count.

// File: rtl/mmu_pkg.sv
package mmu_pkg;

    localparam int ADDR_W  = 32;
    localparam int DATA_W  = 32;
    localparam int OFS_W   = 12;
    localparam int PX_W    = ADDR_W - OFS_W;
    localparam int WORD_SH = 2;
    localparam int PAD_W   = ADDR_W - PX_W - WORD_SH;
    localparam int CAUSE_W = 2;
    localparam int FLAG_W  = 3;

    // entry flag positions
    localparam int PTE_V = 0;
    localparam int PTE_W = 1;
    localparam int PTE_R = 2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADD,
        S_SETA,
        S_RDPTE,
        S_CHECK,
        S_READ,
        S_WRITE
    } walk_state_e;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_LEN  = 2'd1,
        CAUSE_PTE  = 2'd2
    } fault_cause_e;

    typedef enum logic [1:0] {
        AR_VA,
        AR_PTE,
        AR_PA
    } ar_src_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] va;
        logic [DATA_W-1:0] wdata;
    } req_t;

    function automatic logic [PX_W-1:0] page_idx(input logic [ADDR_W-1:0] va);
        return va[ADDR_W-1 -: PX_W];
    endfunction

    function automatic logic [ADDR_W-1:0] entry_addr(input logic [PX_W-1:0] origin,
                                                     input logic [PX_W-1:0] px);
        return {origin, {OFS_W{1'b0}}} + {{PAD_W{1'b0}}, px, {WORD_SH{1'b0}}};
    endfunction

    function automatic logic [ADDR_W-1:0] phys_addr(input logic [DATA_W-1:0] pte,
                                                    input logic [ADDR_W-1:0] va);
        return {pte[DATA_W-1 -: PX_W], va[OFS_W-1:0]};
    endfunction

endpackage

// File: rtl/mmu_pte_check.sv
module mmu_pte_check
    import mmu_pkg::*;
(
    input  logic [FLAG_W-1:0] flags,
    input  logic              is_store,
    output logic              granted
);

    always_comb begin
        granted = flags[PTE_V] && (is_store ? flags[PTE_W] : flags[PTE_R]);
    end

endmodule

// File: rtl/mmu_walk_fsm.sv
module mmu_walk_fsm
    import mmu_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    cpu_req,
    input  logic    walk_stall,
    input  logic    mode_user,
    input  logic    req_wr,
    input  logic    len_fault,
    input  logic    pte_granted,
    input  logic    mem_busy,
    output logic    cap_req,
    output logic    ar_ce,
    output ar_src_e ar_src,
    output logic    dr_ce,
    output logic    len_exc,
    output logic    pte_exc,
    output logic    mem_rd,
    output logic    mem_wr,
    output logic    busy
);

    walk_state_e state, nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        nxt     = state;
        cap_req = 1'b0;
        ar_ce   = 1'b0;
        ar_src  = AR_VA;
        dr_ce   = 1'b0;
        len_exc = 1'b0;
        pte_exc = 1'b0;
        mem_rd  = 1'b0;
        mem_wr  = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (cpu_req && !walk_stall) begin
                    cap_req = 1'b1;
                    nxt     = mode_user ? S_ADD : S_SETA;
                end
            end
            S_ADD: begin
                if (len_fault) begin
                    len_exc = 1'b1;
                    nxt     = S_IDLE;
                end else begin
                    ar_ce  = 1'b1;
                    ar_src = AR_PTE;
                    nxt    = S_RDPTE;
                end
            end
            S_SETA: begin
                ar_ce  = 1'b1;
                ar_src = AR_VA;
                nxt    = req_wr ? S_WRITE : S_READ;
            end
            S_RDPTE: begin
                mem_rd = 1'b1;
                if (!mem_busy) begin
                    dr_ce = 1'b1;
                    nxt   = S_CHECK;
                end
            end
            S_CHECK: begin
                if (!pte_granted) begin
                    pte_exc = 1'b1;
                    nxt     = S_IDLE;
                end else begin
                    ar_ce  = 1'b1;
                    ar_src = AR_PA;
                    nxt    = req_wr ? S_WRITE : S_READ;
                end
            end
            S_READ: begin
                mem_rd = 1'b1;
                if (!mem_busy) begin
                    dr_ce = 1'b1;
                    nxt   = S_IDLE;
                end
            end
            S_WRITE: begin
                mem_wr = 1'b1;
                if (!mem_busy) nxt = S_IDLE;
            end
            default: nxt = S_IDLE;
        endcase
    end

    assign busy = (state != S_IDLE);

endmodule

// File: rtl/mmu_datapath.sv
module mmu_datapath
    import mmu_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cap_req,
    input  logic               ar_ce,
    input  ar_src_e            ar_src,
    input  logic               dr_ce,
    input  logic               len_exc,
    input  logic               pte_exc,
    input  logic               cpu_wr,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [DATA_W-1:0]  cpu_wdata,
    input  logic [PX_W-1:0]    pt_origin,
    input  logic [PX_W-1:0]    pt_length,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               len_fault,
    output logic               req_wr,
    output logic [FLAG_W-1:0]  pte_flags,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic [DATA_W-1:0]  cpu_rdata,
    output logic               cpu_excp,
    output logic [CAUSE_W-1:0] cpu_cause
);

    req_t              req_q;
    logic [ADDR_W-1:0] ar_q, ar_d;
    logic [DATA_W-1:0] dr_q;
    logic              excp_q;
    fault_cause_e      cause_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else if (cap_req) begin
            req_q.wr    <= cpu_wr;
            req_q.va    <= cpu_addr;
            req_q.wdata <= cpu_wdata;
        end
    end

    always_comb begin
        unique case (ar_src)
            AR_PTE:  ar_d = entry_addr(pt_origin, page_idx(req_q.va));
            AR_PA:   ar_d = phys_addr(dr_q, req_q.va);
            default: ar_d = req_q.va;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ar_q <= '0;
            dr_q <= '0;
        end else begin
            if (ar_ce) ar_q <= ar_d;
            if (dr_ce) dr_q <= mem_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            excp_q  <= 1'b0;
            cause_q <= CAUSE_NONE;
        end else begin
            excp_q  <= len_exc || pte_exc;
            cause_q <= len_exc ? CAUSE_LEN : (pte_exc ? CAUSE_PTE : CAUSE_NONE);
        end
    end

    assign len_fault = !(page_idx(req_q.va) < pt_length);
    assign req_wr    = req_q.wr;
    assign pte_flags = dr_q[FLAG_W-1:0];
    assign mem_addr  = ar_q;
    assign mem_wdata = req_q.wdata;
    assign cpu_rdata = dr_q;
    assign cpu_excp  = excp_q;
    assign cpu_cause = cause_q;

endmodule

// File: rtl/pt_walk_mmu.sv
module pt_walk_mmu
    import mmu_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cpu_req,
    input  logic               cpu_wr,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [DATA_W-1:0]  cpu_wdata,
    output logic               cpu_busy,
    output logic [DATA_W-1:0]  cpu_rdata,
    output logic               cpu_excp,
    output logic [CAUSE_W-1:0] cpu_cause,
    input  logic               mode_user,
    input  logic [PX_W-1:0]    pt_origin,
    input  logic [PX_W-1:0]    pt_length,
    input  logic               walk_stall,
    output logic               mem_rd,
    output logic               mem_wr,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic [DATA_W-1:0]  mem_rdata,
    input  logic               mem_busy
);

    logic              cap_req, ar_ce, dr_ce, len_exc, pte_exc;
    logic              len_fault, req_wr, pte_granted;
    ar_src_e           ar_src;
    logic [FLAG_W-1:0] pte_flags;

    mmu_walk_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .cpu_req     (cpu_req),
        .walk_stall  (walk_stall),
        .mode_user   (mode_user),
        .req_wr      (req_wr),
        .len_fault   (len_fault),
        .pte_granted (pte_granted),
        .mem_busy    (mem_busy),
        .cap_req     (cap_req),
        .ar_ce       (ar_ce),
        .ar_src      (ar_src),
        .dr_ce       (dr_ce),
        .len_exc     (len_exc),
        .pte_exc     (pte_exc),
        .mem_rd      (mem_rd),
        .mem_wr      (mem_wr),
        .busy        (cpu_busy)
    );

    mmu_datapath u_dp (
        .clk        (clk),
        .rst        (rst),
        .cap_req    (cap_req),
        .ar_ce      (ar_ce),
        .ar_src     (ar_src),
        .dr_ce      (dr_ce),
        .len_exc    (len_exc),
        .pte_exc    (pte_exc),
        .cpu_wr     (cpu_wr),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .pt_origin  (pt_origin),
        .pt_length  (pt_length),
        .mem_rdata  (mem_rdata),
        .len_fault  (len_fault),
        .req_wr     (req_wr),
        .pte_flags  (pte_flags),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .cpu_rdata  (cpu_rdata),
        .cpu_excp   (cpu_excp),
        .cpu_cause  (cpu_cause)
    );

    mmu_pte_check u_chkpte (
        .flags    (pte_flags),
        .is_store (req_wr),
        .granted  (pte_granted)
    );

endmodule

// File: rtl/mmu_walk_chk.sv
module mmu_walk_chk
    import mmu_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               cpu_busy,
    input logic               cpu_excp,
    input logic [CAUSE_W-1:0] cpu_cause,
    input logic               walk_stall,
    input logic               mem_rd,
    input logic               mem_wr,
    input logic               mem_busy,
    input logic [ADDR_W-1:0]  mem_addr
);

    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((mem_rd || mem_wr) && mem_busy) |=>
            (mem_rd == $past(mem_rd)) && (mem_wr == $past(mem_wr)) && $stable(mem_addr));

    // R11
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // R10
    excp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_excp |=> !cpu_excp);

    // R10
    excp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_excp |-> (!cpu_busy && (cpu_cause != 2'd0)));

    // R7
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cpu_busy) |-> (cpu_excp || ($past(mem_rd || mem_wr) && !$past(mem_busy))));

    // R7
    strobe_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd || mem_wr) |-> cpu_busy);

    // R3
    len_noaccess_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_excp && (cpu_cause == 2'd1)) |-> !$past(mem_rd || mem_wr));

    // R12
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!cpu_busy && walk_stall) |=> !cpu_busy);

endmodule

bind pt_walk_mmu mmu_walk_chk u_walk_chk (
    .clk        (clk),
    .rst        (rst),
    .cpu_busy   (cpu_busy),
    .cpu_excp   (cpu_excp),
    .cpu_cause  (cpu_cause),
    .walk_stall (walk_stall),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .mem_busy   (mem_busy),
    .mem_addr   (mem_addr)
);

// File: tb/pt_walk_mmu_tb.sv
module pt_walk_mmu_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam logic [19:0] ORIGIN = 20'h00010;
    localparam logic [19:0] LENGTH = 20'h00008;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_wr = 1'b0, mode_user = 1'b0, walk_stall = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic        cpu_busy, cpu_excp, mem_rd, mem_wr, mem_busy;
    logic [1:0]  cpu_cause;
    logic [31:0] cpu_rdata, mem_addr, mem_wdata;
    logic [31:0] mem_rdata;
    logic [19:0] pt_origin = ORIGIN, pt_length = LENGTH;

    int n_chk = 0, n_bad = 0;
    int lat = 0, wcnt = 0, wr_gen = 0;

    logic [31:0] mem [logic [31:0]];

    always #(CLK_PERIOD/2) clk = ~clk;

    pt_walk_mmu u_dut (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_busy(cpu_busy), .cpu_rdata(cpu_rdata), .cpu_excp(cpu_excp), .cpu_cause(cpu_cause),
        .mode_user(mode_user), .pt_origin(pt_origin), .pt_length(pt_length),
        .walk_stall(walk_stall),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_busy(mem_busy)
    );

    function automatic logic [31:0] peek(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return 32'hDEAD_0000 ^ a;
    endfunction

    // memory model: busy for lat cycles per strobed access
    assign mem_busy = (mem_rd || mem_wr) && (wcnt != lat);
    always @(mem_addr or wr_gen) mem_rdata = peek(mem_addr);

    always @(posedge clk) begin
        if (mem_rd || mem_wr) begin
            if (mem_busy) wcnt <= wcnt + 1;
            else begin
                wcnt <= 0;
                if (mem_wr) begin
                    mem[mem_addr] = mem_wdata;
                    wr_gen = wr_gen + 1;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    typedef struct {
        string       tag;
        logic        excp;
        logic [1:0]  cause;
        logic        chk_data;
        logic [31:0] rdata;
        int          nacc;
        logic [31:0] first;
        logic [31:0] last;
        int          cycles;
    } exp_t;

    exp_t sbq[$];

    // independent model of one request
    function automatic exp_t model(input string tag, input logic user, input logic wr,
                                   input logic [31:0] va);
        exp_t e;
        logic [31:0] pa, pte, ea;
        e.tag = tag; e.excp = 1'b0; e.cause = 2'd0; e.chk_data = 1'b0; e.rdata = '0;
        if (!user) begin
            pa = va;
            e.nacc = 1; e.first = pa; e.last = pa; e.cycles = 2 + lat;
        end else if (va[31:12] >= pt_length) begin
            e.excp = 1'b1; e.cause = 2'd1; e.nacc = 0; e.first = '0; e.last = '0; e.cycles = 1;
            return e;
        end else begin
            ea  = {pt_origin, 12'h000} + {10'd0, va[31:12], 2'b00};
            pte = peek(ea);
            if (!pte[0] || (wr ? !pte[1] : !pte[2])) begin
                e.excp = 1'b1; e.cause = 2'd2; e.nacc = 1; e.first = ea; e.last = ea;
                e.cycles = 3 + lat;
                return e;
            end
            pa = {pte[31:12], va[11:0]};
            e.nacc = 2; e.first = ea; e.last = pa; e.cycles = 4 + 2 * lat;
        end
        if (!wr) begin
            e.chk_data = 1'b1;
            e.rdata = peek(pa);
        end
        return e;
    endfunction

    // driver
    task automatic issue(input string tag, input logic user, input logic wr,
                         input logic [31:0] va, input logic [31:0] wd, input int stall_cyc);
        sbq.push_back(model(tag, user, wr, va));
        @(negedge clk);
        mode_user = user; cpu_wr = wr; cpu_addr = va; cpu_wdata = wd; cpu_req = 1'b1;
        if (stall_cyc > 0) begin
            walk_stall = 1'b1;
            for (int i = 0; i < stall_cyc; i++) begin
                @(negedge clk);
                check(!cpu_busy && !mem_rd && !mem_wr, "R12", "stalled request started",
                      {29'd0, cpu_busy, mem_rd, mem_wr}, 32'd0);
            end
            walk_stall = 1'b0;
        end
        do @(negedge clk); while (!cpu_busy);
        cpu_req = 1'b0;
        while (cpu_busy) @(negedge clk);
        @(negedge clk);
        check(!cpu_excp, "R10", "flag longer than one cycle", {31'd0, cpu_excp}, 32'd0);
    endtask

    // monitor
    int          m_nacc = 0, m_cyc = 0;
    logic [31:0] m_first = '0, m_last = '0;
    logic        prev_busy = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if ((mem_rd || mem_wr) && !mem_busy) begin
                if (m_nacc == 0) m_first = mem_addr;
                m_last = mem_addr;
                m_nacc++;
            end
            if (cpu_busy) m_cyc++;
            if (prev_busy && !cpu_busy) begin
                if (sbq.size() == 0) begin
                    check(1'b0, "R7", "unexpected completion", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    check(cpu_excp == e.excp, {e.tag, " R10"}, "fault flag", {31'd0, cpu_excp}, {31'd0, e.excp});
                    if (e.excp)
                        check(cpu_cause == e.cause, {e.tag, " R10"}, "cause", {30'd0, cpu_cause}, {30'd0, e.cause});
                    check(m_nacc == e.nacc, e.tag, "access count", m_nacc, e.nacc);
                    if (e.nacc > 0) begin
                        check(m_first == e.first, {e.tag, " R1"}, "first address", m_first, e.first);
                        check(m_last == e.last, {e.tag, " R2"}, "last address", m_last, e.last);
                    end
                    check(m_cyc == e.cycles, {e.tag, " R7"}, "busy cycles", m_cyc, e.cycles);
                    if (e.chk_data)
                        check(cpu_rdata == e.rdata, {e.tag, " R8"}, "load data", cpu_rdata, e.rdata);
                end
                m_nacc = 0;
                m_cyc  = 0;
            end
            prev_busy = cpu_busy;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // page table entries: ppx[31:12], r bit2, w bit1, v bit0
        mem[32'h0001_0000] = 32'h0020_0007; // px0 rwv
        mem[32'h0001_0004] = 32'h0020_1005; // px1 r only
        mem[32'h0001_0008] = 32'h0020_2003; // px2 w only
        mem[32'h0001_000C] = 32'h0020_3006; // px3 invalid
        mem[32'h0001_001C] = 32'h0020_7007; // px7 last legal
        mem[32'h0020_0010] = 32'hA5A5_0001;
        mem[32'h0020_1FFC] = 32'h1234_5678;
        mem[32'h0020_7100] = 32'hCAFE_0007;
        mem[32'h0000_4000] = 32'h5555_AAAA;
        wr_gen = 1;

        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!cpu_busy && !cpu_excp && !mem_rd && !mem_wr, "R7", "reset state",
              {28'd0, cpu_busy, cpu_excp, mem_rd, mem_wr}, 32'd0);

        // R6 system mode pass-through
        lat = 0;
        issue("R6 sys load", 1'b0, 1'b0, 32'h0000_4000, 32'h0, 0);
        issue("R6 R9 sys store", 1'b0, 1'b1, 32'h0000_4008, 32'h0BAD_F00D, 0);
        check(peek(32'h0000_4008) == 32'h0BAD_F00D, "R9", "stored word", peek(32'h0000_4008), 32'h0BAD_F00D);
        issue("R6 R8 sys readback", 1'b0, 1'b0, 32'h0000_4008, 32'h0, 0);

        // R1 R2 user translation
        issue("R1 R2 user load px0", 1'b1, 1'b0, 32'h0000_0010, 32'h0, 0);
        lat = 2;
        issue("R9 user store px0", 1'b1, 1'b1, 32'h0000_0020, 32'h7777_1111, 0);
        check(peek(32'h0020_0020) == 32'h7777_1111, "R9", "translated store", peek(32'h0020_0020), 32'h7777_1111);
        issue("R8 user readback px0", 1'b1, 1'b0, 32'h0000_0020, 32'h0, 0);

        // R5 rights
        issue("R5 load read-only", 1'b1, 1'b0, 32'h0000_1FFC, 32'h0, 0);
        issue("R5 store read-only", 1'b1, 1'b1, 32'h0000_1FFC, 32'hFFFF_0000, 0);
        check(peek(32'h0020_1FFC) == 32'h1234_5678, "R5", "denied store changed memory", peek(32'h0020_1FFC), 32'h1234_5678);
        lat = 0;
        issue("R5 store write-only", 1'b1, 1'b1, 32'h0000_2040, 32'h2222_3333, 0);
        issue("R5 load write-only", 1'b1, 1'b0, 32'h0000_2040, 32'h0, 0);

        // R4 invalid entry
        lat = 3;
        issue("R4 invalid entry", 1'b1, 1'b0, 32'h0000_3000, 32'h0, 0);
        issue("R4 invalid entry store", 1'b1, 1'b1, 32'h0000_3004, 32'h1, 0);

        // R3 length boundary
        issue("R3 last legal index", 1'b1, 1'b0, 32'h0000_7100, 32'h0, 0);
        issue("R3 index equals length", 1'b1, 1'b0, 32'h0000_8000, 32'h0, 0);
        issue("R3 max index", 1'b1, 1'b1, 32'hFFFF_F000, 32'h0, 0);

        // R12 stall
        lat = 1;
        issue("R12 stalled user load", 1'b1, 1'b0, 32'h0000_0010, 32'h0, 4);
        issue("R12 stalled sys load", 1'b0, 1'b0, 32'h0000_4000, 32'h0, 3);

        repeat (2) @(negedge clk);
        check(sbq.size() == 0, "R7", "outstanding items", sbq.size(), 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule